// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the purely combinational execute stage of a 32-bit load/store processor with three-address instructions. A decoded operation code selects one of thirty functions. The operands come from two register values, a 16-bit immediate field, a fixed shift amount, the current program counter and a word already read from data memory together with the byte offset of the access. Every function drives all 32 bits of the result.

The unit covers add, subtract, bitwise logic, shifts, set-less-than and upper-immediate load. It also picks and extends bytes and halfwords out of the loaded word and forms the return address for linking jumps. How an immediate is widened depends only on the class of the operation: logical forms zero-fill it, and arithmetic and compare forms copy its sign bit, including the unsigned-named forms. A trap flag is raised only by the three trapping signed arithmetic forms. When it is raised, the register write enable is withdrawn in the same cycle.

Top module: `exu_core`

## Requirements
- R1: For ANDI (18), ORI (19) and XORI (20) the immediate is zero-filled to 32 bits before the operation, so an immediate of 0xFFFF acts as 0x0000FFFF.
- R2: For ADDI (16), ADDIU (17), SLTI (21) and SLTIU (22) the immediate is sign-filled to 32 bits, so 0xFFFF acts as 0xFFFFFFFF. SLTIU then compares unsigned.
- R3: `ovf_o` is 1 exactly when ADD (0), SUB (2) or ADDI (16) produces a result that does not fit in 32-bit two's complement. For SUB the second operand is rs minus rt.
- R4: `ovf_o` stays 0 for every other operation code, including ADDU (1), SUBU (3), ADDIU (17), the logic and the shift operations, even when the same operands would overflow a signed sum.
- R5: `wr_en_o` is 1 for every defined code (0 to 29) unless `ovf_o` is 1. For codes 30 and 31 both `wr_en_o` and `result_o` are 0.
- R6: LB (24), LBU (25), LH (26), LHU (27) and LW (28) take the loaded word big-endian. Byte offset 0 selects bits 31:24 and offset 3 selects bits 7:0. A halfword uses only offset bit 1, where 0 selects bits 31:16. LB and LH sign-fill, LBU and LHU zero-fill, and LW passes the word unchanged.
- R7: LUI (23) returns the immediate in bits 31:16 with bits 15:0 cleared.
- R8: LINK (29) returns the program counter input plus 4.
- R9: SLT (8), SLTU (9), SLTI and SLTIU return 1 or 0 in bit 0 with bits 31:1 cleared. SLT and SLTI compare signed, SLTU and SLTIU unsigned.
- R10: SLL (10), SRL (11) and SRA (12) shift rt by `shamt_i`. SLLV (13), SRLV (14) and SRAV (15) shift rt by rs bits 4:0. The SRA forms replicate rt bit 31.
- R11: ADD, ADDU, SUB, SUBU, AND (4), OR (5), XOR (6) and NOR (7) on rs and rt return the 32-bit wrapped sum or difference or the bitwise result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Decoded operation code |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand, also the shifted value |
| imm_i | input | 16 | Immediate field of the instruction |
| shamt_i | input | 5 | Fixed shift amount |
| pc_i | input | 32 | Address of the current instruction |
| mem_word_i | input | 32 | Word read from data memory |
| mem_off_i | input | 2 | Byte offset of the load within the word |
| result_o | output | 32 | Full-width result |
| ovf_o | output | 1 | Signed-overflow trap flag |
| wr_en_o | output | 1 | Destination register write enable |

## Verification
The hardest cases to reach are the overflow boundaries: a sum one step past the most positive value, a difference one step below the most negative value, and the same operand pairs given to the non-trapping forms, where the flag must stay low. Uniform random operands almost never hit them. The stimulus therefore draws each operand from a pool weighted toward 0, 1, all-ones, 0x7FFFFFFF and 0x80000000, and it also runs directed vectors across every byte and halfword offset with the sign bit set and clear. Each vector is checked against a behavioural model that works in 64-bit integers.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned OPW  = 5;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDU  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,  OP_OR    = 5'd5,  OP_XOR   = 5'd6,  OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,  OP_SLTU  = 5'd9,  OP_SLL   = 5'd10, OP_SRL   = 5'd11,
    OP_SRA   = 5'd12, OP_SLLV  = 5'd13, OP_SRLV  = 5'd14, OP_SRAV  = 5'd15,
    OP_ADDI  = 5'd16, OP_ADDIU = 5'd17, OP_ANDI  = 5'd18, OP_ORI   = 5'd19,
    OP_XORI  = 5'd20, OP_SLTI  = 5'd21, OP_SLTIU = 5'd22, OP_LUI   = 5'd23,
    OP_LB    = 5'd24, OP_LBU   = 5'd25, OP_LH    = 5'd26, OP_LHU   = 5'd27,
    OP_LW    = 5'd28, OP_LINK  = 5'd29
  } exu_op_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ARITH, SEL_LOGIC, SEL_CMP,
    SEL_SHIFT, SEL_LUI, SEL_LOAD, SEL_LINK
  } res_sel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_fn_e;
  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARITH} shift_fn_e;
  typedef enum logic [1:0] {LD_BYTE, LD_HALF, LD_WORD} ld_size_e;

  typedef struct packed {
    logic      valid;
    res_sel_e  sel;
    logic      use_imm;
    logic      imm_signed;
    logic      sub;
    logic      trap_en;
    logic      cmp_signed;
    logic_fn_e lfn;
    shift_fn_e sfn;
    logic      shamt_reg;
    ld_size_e  lsize;
    logic      ld_signed;
  } exu_ctrl_t;

  function automatic logic [XLEN-1:0] exu_logic(input logic_fn_e fn,
                                                input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
    case (fn)
      LG_AND:  return a & b;
      LG_OR:   return a | b;
      LG_XOR:  return a ^ b;
      default: return ~(a | b);
    endcase
  endfunction

  function automatic exu_ctrl_t exu_decode(input logic [OPW-1:0] op);
    exu_ctrl_t c;
    c = '0;
    c.valid = 1'b1;
    case (op)
      OP_ADD:   begin c.sel = SEL_ARITH; c.trap_en = 1'b1; end
      OP_ADDU:  c.sel = SEL_ARITH;
      OP_SUB:   begin c.sel = SEL_ARITH; c.sub = 1'b1; c.trap_en = 1'b1; end
      OP_SUBU:  begin c.sel = SEL_ARITH; c.sub = 1'b1; end
      OP_AND:   begin c.sel = SEL_LOGIC; c.lfn = LG_AND; end
      OP_OR:    begin c.sel = SEL_LOGIC; c.lfn = LG_OR; end
      OP_XOR:   begin c.sel = SEL_LOGIC; c.lfn = LG_XOR; end
      OP_NOR:   begin c.sel = SEL_LOGIC; c.lfn = LG_NOR; end
      OP_SLT:   begin c.sel = SEL_CMP; c.cmp_signed = 1'b1; end
      OP_SLTU:  c.sel = SEL_CMP;
      OP_SLL:   begin c.sel = SEL_SHIFT; c.sfn = SH_LEFT; end
      OP_SRL:   begin c.sel = SEL_SHIFT; c.sfn = SH_RLOG; end
      OP_SRA:   begin c.sel = SEL_SHIFT; c.sfn = SH_RARITH; end
      OP_SLLV:  begin c.sel = SEL_SHIFT; c.sfn = SH_LEFT; c.shamt_reg = 1'b1; end
      OP_SRLV:  begin c.sel = SEL_SHIFT; c.sfn = SH_RLOG; c.shamt_reg = 1'b1; end
      OP_SRAV:  begin c.sel = SEL_SHIFT; c.sfn = SH_RARITH; c.shamt_reg = 1'b1; end
      OP_ADDI:  begin c.sel = SEL_ARITH; c.use_imm = 1'b1; c.imm_signed = 1'b1;
                      c.trap_en = 1'b1; end
      OP_ADDIU: begin c.sel = SEL_ARITH; c.use_imm = 1'b1; c.imm_signed = 1'b1; end
      OP_ANDI:  begin c.sel = SEL_LOGIC; c.lfn = LG_AND; c.use_imm = 1'b1; end
      OP_ORI:   begin c.sel = SEL_LOGIC; c.lfn = LG_OR;  c.use_imm = 1'b1; end
      OP_XORI:  begin c.sel = SEL_LOGIC; c.lfn = LG_XOR; c.use_imm = 1'b1; end
      OP_SLTI:  begin c.sel = SEL_CMP; c.use_imm = 1'b1; c.imm_signed = 1'b1;
                      c.cmp_signed = 1'b1; end
      OP_SLTIU: begin c.sel = SEL_CMP; c.use_imm = 1'b1; c.imm_signed = 1'b1; end
      OP_LUI:   c.sel = SEL_LUI;
      OP_LB:    begin c.sel = SEL_LOAD; c.lsize = LD_BYTE; c.ld_signed = 1'b1; end
      OP_LBU:   begin c.sel = SEL_LOAD; c.lsize = LD_BYTE; end
      OP_LH:    begin c.sel = SEL_LOAD; c.lsize = LD_HALF; c.ld_signed = 1'b1; end
      OP_LHU:   begin c.sel = SEL_LOAD; c.lsize = LD_HALF; end
      OP_LW:    begin c.sel = SEL_LOAD; c.lsize = LD_WORD; end
      OP_LINK:  c.sel = SEL_LINK;
      default:  begin c.valid = 1'b0; c.sel = SEL_NONE; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/exu_imm_ext.sv
module exu_imm_ext #(
  parameter int unsigned W    = exu_pkg::XLEN,
  parameter int unsigned IMMW = 16
) (
  input  logic [IMMW-1:0] imm_i,
  input  logic            sign_i,
  output logic [W-1:0]    ext_o
);
  localparam int unsigned FILLW = W - IMMW;

  logic fill_bit;

  always_comb begin
    fill_bit = sign_i & imm_i[IMMW-1];
    ext_o    = {{FILLW{fill_bit}}, imm_i};
    p_low_kept_r2: assert (ext_o[IMMW-1:0] == imm_i)
      else $error("immediate low field altered");
    p_zero_fill_r1: assert (sign_i || ext_o[W-1:IMMW] == '0)
      else $error("zero-filled immediate has upper bits set");
  end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int unsigned W = exu_pkg::XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide_chk;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    wide_chk = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                     : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
    p_ovf_range_r3: assert (ovf_o == (wide_chk[W] != wide_chk[W-1]))
      else $error("overflow flag disagrees with widened result");
    p_sum_wrap_r11: assert (sum_o == wide_chk[W-1:0])
      else $error("wrapped sum disagrees with widened result");
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int unsigned W = exu_pkg::XLEN,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]        val_i,
  input  logic [SHW-1:0]      amt_i,
  input  exu_pkg::shift_fn_e  fn_i,
  output logic [W-1:0]        res_o
);
  import exu_pkg::*;

  always_comb begin
    case (fn_i)
      SH_LEFT:   res_o = val_i << amt_i;
      SH_RLOG:   res_o = val_i >> amt_i;
      SH_RARITH: res_o = W'($signed(val_i) >>> amt_i);
      default:   res_o = val_i;
    endcase
    p_sra_sign_r10: assert (fn_i != SH_RARITH || res_o[W-1] == val_i[W-1])
      else $error("arithmetic shift lost the sign bit");
    p_srl_top_r10: assert (fn_i != SH_RLOG || amt_i == '0 || !res_o[W-1])
      else $error("logical right shift filled with one");
  end
endmodule

// File: rtl/exu_load_align.sv
module exu_load_align #(
  parameter int unsigned W = exu_pkg::XLEN,
  localparam int unsigned LANES  = W / 8,
  localparam int unsigned HALVES = W / 16,
  localparam int unsigned OFFW   = $clog2(LANES)
) (
  input  logic [W-1:0]       word_i,
  input  logic [OFFW-1:0]    off_i,
  input  exu_pkg::ld_size_e  size_i,
  input  logic               sign_i,
  output logic [W-1:0]       data_o
);
  import exu_pkg::*;

  logic [7:0]  lane  [LANES];
  logic [15:0] halfw [HALVES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = word_i[W-1-8*k -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign halfw[h] = word_i[W-1-16*h -: 16];
  end

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = lane[off_i];
    half_sel = halfw[off_i[OFFW-1:1]];
    case (size_i)
      LD_BYTE: data_o = {{(W-8){sign_i & byte_sel[7]}}, byte_sel};
      LD_HALF: data_o = {{(W-16){sign_i & half_sel[15]}}, half_sel};
      default: data_o = word_i;
    endcase
    p_ubyte_clear_r6: assert (size_i != LD_BYTE || sign_i || data_o[W-1:8] == '0)
      else $error("unsigned byte load has upper bits set");
    p_shalf_fill_r6: assert (size_i != LD_HALF || !sign_i ||
                             data_o[W-1:16] == {(W-16){data_o[15]}})
      else $error("signed halfword load not sign filled");
  end
endmodule

// File: rtl/exu_core.sv
module exu_core #(
  parameter int unsigned XLEN      = exu_pkg::XLEN,
  parameter int unsigned IMMW      = 16,
  parameter int unsigned LINK_STEP = 4,
  localparam int unsigned SHW  = $clog2(XLEN),
  localparam int unsigned OFFW = $clog2(XLEN / 8)
) (
  input  logic [exu_pkg::OPW-1:0] op_i,
  input  logic [XLEN-1:0]         rs_val_i,
  input  logic [XLEN-1:0]         rt_val_i,
  input  logic [IMMW-1:0]         imm_i,
  input  logic [SHW-1:0]          shamt_i,
  input  logic [XLEN-1:0]         pc_i,
  input  logic [XLEN-1:0]         mem_word_i,
  input  logic [OFFW-1:0]         mem_off_i,
  output logic [XLEN-1:0]         result_o,
  output logic                    ovf_o,
  output logic                    wr_en_o
);
  import exu_pkg::*;

  exu_ctrl_t       ctrl;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] operand_b;
  logic [XLEN-1:0] sum;
  logic            add_ovf;
  logic [XLEN-1:0] logic_res;
  logic [XLEN-1:0] shift_res;
  logic [SHW-1:0]  shift_amt;
  logic [XLEN-1:0] load_res;
  logic [XLEN-1:0] link_res;
  logic [XLEN-1:0] lui_res;
  logic            less_than;
  logic            trap_raised;

  assign ctrl      = exu_decode(op_i);
  assign operand_b = ctrl.use_imm ? imm_ext : rt_val_i;
  assign shift_amt = ctrl.shamt_reg ? rs_val_i[SHW-1:0] : shamt_i;
  assign logic_res = exu_logic(ctrl.lfn, rs_val_i, operand_b);
  assign link_res  = pc_i + XLEN'(LINK_STEP);
  assign lui_res   = {imm_i, {(XLEN-IMMW){1'b0}}};
  assign less_than = ctrl.cmp_signed ? ($signed(rs_val_i) < $signed(operand_b))
                                     : (rs_val_i < operand_b);

  exu_imm_ext #(.W(XLEN), .IMMW(IMMW)) i_imm_ext (
    .imm_i  (imm_i),
    .sign_i (ctrl.imm_signed),
    .ext_o  (imm_ext)
  );

  exu_addsub #(.W(XLEN)) i_addsub (
    .a_i   (rs_val_i),
    .b_i   (operand_b),
    .sub_i (ctrl.sub),
    .sum_o (sum),
    .ovf_o (add_ovf)
  );

  exu_shifter #(.W(XLEN)) i_shifter (
    .val_i (rt_val_i),
    .amt_i (shift_amt),
    .fn_i  (ctrl.sfn),
    .res_o (shift_res)
  );

  exu_load_align #(.W(XLEN)) i_load_align (
    .word_i (mem_word_i),
    .off_i  (mem_off_i),
    .size_i (ctrl.lsize),
    .sign_i (ctrl.ld_signed),
    .data_o (load_res)
  );

  always_comb begin
    case (ctrl.sel)
      SEL_ARITH: result_o = sum;
      SEL_LOGIC: result_o = logic_res;
      SEL_CMP:   result_o = {{(XLEN-1){1'b0}}, less_than};
      SEL_SHIFT: result_o = shift_res;
      SEL_LUI:   result_o = lui_res;
      SEL_LOAD:  result_o = load_res;
      SEL_LINK:  result_o = link_res;
      default:   result_o = '0;
    endcase
    trap_raised = add_ovf & ctrl.trap_en;
    ovf_o       = trap_raised;
    wr_en_o     = ctrl.valid & ~trap_raised;

    p_no_overflow_r4: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB ||
                              op_i == OP_ADDI)
      else $error("overflow flag from a non-trapping operation");
    p_ovf_blocks_write_r5: assert (!(ovf_o && wr_en_o))
      else $error("write enabled together with overflow");
    p_undef_quiet_r5: assert (ctrl.valid || (result_o == '0 && !wr_en_o))
      else $error("undefined code produced a write or a result");
    p_cmp_bit0_r9: assert (ctrl.sel != SEL_CMP || result_o[XLEN-1:1] == '0)
      else $error("compare result has upper bits set");
    p_lui_low_r7: assert (op_i != OP_LUI || result_o[XLEN-IMMW-1:0] == '0)
      else $error("upper-immediate result has low bits set");
  end
endmodule

// File: tb/test_exu_core.sv
module test_exu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [31:0] rs, rt, pc, mw;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic [1:0]  off;
  logic [31:0] result;
  logic        ovf, we;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exu_core i_exu_core (
    .op_i       (op),
    .rs_val_i   (rs),
    .rt_val_i   (rt),
    .imm_i      (imm),
    .shamt_i    (sh),
    .pc_i       (pc),
    .mem_word_i (mw),
    .mem_off_i  (off),
    .result_o   (result),
    .ovf_o      (ovf),
    .wr_en_o    (we)
  );

  function automatic logic fits32(input longint v);
    return (v <= 64'sd2147483647) && (v >= -64'sd2147483648);
  endfunction

  // Behavioural model of the requirements, in 64-bit integers.
  function automatic void ref_exec(input int o, input logic [31:0] a, input logic [31:0] b,
                                   input logic [15:0] im, input logic [4:0] s,
                                   input logic [31:0] p, input logic [31:0] m,
                                   input logic [1:0] bo,
                                   output logic [31:0] r, output logic v, output logic w);
    logic [31:0] zx, sx;
    longint sa, sb, sz;
    logic [7:0]  by;
    logic [15:0] hw;
    zx = {16'h0000, im};
    sx = {{16{im[15]}}, im};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sz = longint'($signed(sx));
    by = m[8*(3-int'(bo)) +: 8];
    hw = bo[1] ? m[15:0] : m[31:16];
    r = 32'h0; v = 1'b0; w = 1'b1;
    case (o)
      0:  begin r = a + b; v = !fits32(sa + sb); end
      1:  r = a + b;
      2:  begin r = a - b; v = !fits32(sa - sb); end
      3:  r = a - b;
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  r = ~(a | b);
      8:  r = (sa < sb) ? 32'd1 : 32'd0;
      9:  r = (a < b) ? 32'd1 : 32'd0;
      10: r = b << s;
      11: r = b >> s;
      12: r = 32'($signed(b) >>> s);
      13: r = b << a[4:0];
      14: r = b >> a[4:0];
      15: r = 32'($signed(b) >>> a[4:0]);
      16: begin r = a + sx; v = !fits32(sa + sz); end
      17: r = a + sx;
      18: r = a & zx;
      19: r = a | zx;
      20: r = a ^ zx;
      21: r = (sa < sz) ? 32'd1 : 32'd0;
      22: r = (a < sx) ? 32'd1 : 32'd0;
      23: r = {im, 16'h0000};
      24: r = {{24{by[7]}}, by};
      25: r = {24'h0, by};
      26: r = {{16{hw[15]}}, hw};
      27: r = {16'h0, hw};
      28: r = m;
      29: r = p + 32'd4;
      default: w = 1'b0;
    endcase
    if (v) w = 1'b0;
  endfunction

  function automatic string res_tag(input int o);
    if (o >= 18 && o <= 20) return "R1";
    if (o == 16 || o == 17) return "R2";
    if (o == 8 || o == 9 || o == 21 || o == 22) return "R9";
    if (o >= 10 && o <= 15) return "R10";
    if (o == 23) return "R7";
    if (o >= 24 && o <= 28) return "R6";
    if (o == 29) return "R8";
    if (o >= 30) return "R5";
    return "R11";
  endfunction

  task automatic check_bit(input string tag, input string what, input logic got,
                           input logic exp, input int o);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d %s got %0b expected %0b", tag, o, what, got, exp);
    end
  endtask

  task automatic run_vec(input int o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] s,
                         input logic [31:0] p, input logic [31:0] m, input logic [1:0] bo);
    logic [31:0] er;
    logic ev, ew;
    @(posedge clk);
    op = 5'(o); rs = a; rt = b; imm = im; sh = s; pc = p; mw = m; off = bo;
    @(negedge clk);
    ref_exec(o, a, b, im, s, p, m, bo, er, ev, ew);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s op=%0d result got %h expected %h", res_tag(o), o, result, er);
    end
    check_bit((o == 0 || o == 2 || o == 16) ? "R3" : "R4", "ovf", ovf, ev, o);
    check_bit("R5", "wr_en", we, ew, o);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm();
    case ($urandom_range(0, 5))
      0: return 16'hFFFF;
      1: return 16'h8000;
      2: return 16'h7FFF;
      3: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    op = 5'd0; rs = '0; rt = '0; imm = '0; sh = '0; pc = '0; mw = '0; off = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero inputs with code 0 give a zero sum, no trap, write on.
    checks++;
    if (result !== 32'h0) begin
      errors++; $display("FAIL R11 reset result got %h expected %h", result, 32'h0);
    end
    check_bit("R3", "reset ovf", ovf, 1'b0, 0);
    check_bit("R5", "reset wr_en", we, 1'b1, 0);
    rst_n = 1'b1;

    // R1: logical immediates zero-filled
    run_vec(18, 32'hFFFF_FFFF, 0, 16'hFFFF, 0, 0, 0, 0);
    run_vec(19, 32'h1234_0000, 0, 16'h8001, 0, 0, 0, 0);
    run_vec(20, 32'hFFFF_FFFF, 0, 16'hFFFF, 0, 0, 0, 0);
    // R2: arithmetic immediates sign-filled, including the unsigned-named form
    run_vec(17, 32'h0000_0005, 0, 16'hFFFF, 0, 0, 0, 0);
    run_vec(22, 32'h0000_0005, 0, 16'hFFFF, 0, 0, 0, 0);
    run_vec(21, 32'h0000_0005, 0, 16'hFFFF, 0, 0, 0, 0);
    // R3: trapping overflow at both boundaries
    run_vec(0,  32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    run_vec(2,  32'h8000_0000, 32'h1, 0, 0, 0, 0, 0);
    run_vec(16, 32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 0, 0);
    run_vec(16, 32'h8000_0000, 0, 16'hFFFF, 0, 0, 0, 0);
    run_vec(0,  32'h7FFF_FFFE, 32'h1, 0, 0, 0, 0, 0);
    // R4: same operands on the non-trapping forms
    run_vec(1,  32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    run_vec(3,  32'h8000_0000, 32'h1, 0, 0, 0, 0, 0);
    run_vec(17, 32'h7FFF_FFFF, 0, 16'h0001, 0, 0, 0, 0);
    run_vec(10, 32'h0, 32'h8000_0001, 0, 5'd1, 0, 0, 0);
    // R5: undefined codes
    run_vec(30, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd3, 32'h100, 32'h5, 0);
    run_vec(31, 32'h1, 32'h2, 16'h3, 5'd4, 32'h200, 32'h6, 1);
    // R6: every byte offset and both halfword halves, sign bit set and clear
    for (int b = 0; b < 4; b++) begin
      run_vec(24, 0, 0, 0, 0, 0, 32'h80_7F_81_01, 2'(b));
      run_vec(25, 0, 0, 0, 0, 0, 32'h80_7F_81_01, 2'(b));
      run_vec(26, 0, 0, 0, 0, 0, 32'h8001_7FFE, 2'(b));
      run_vec(27, 0, 0, 0, 0, 0, 32'h8001_7FFE, 2'(b));
      run_vec(28, 0, 0, 0, 0, 0, 32'hDEAD_BEEF, 2'(b));
    end
    // R7, R8
    run_vec(23, 32'hFFFF_FFFF, 0, 16'hABCD, 0, 0, 0, 0);
    run_vec(29, 0, 0, 0, 0, 32'hFFFF_FFFC, 0, 0);
    run_vec(29, 0, 0, 0, 0, 32'h0040_0010, 0, 0);
    // R9: signed versus unsigned compare of -1 and 1
    run_vec(8, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    run_vec(9, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    // R10: arithmetic right shift of a negative value, fixed and variable
    run_vec(12, 32'h0, 32'h8000_0000, 0, 5'd31, 0, 0, 0);
    run_vec(15, 32'hFFFF_FFE4, 32'h8000_0000, 0, 5'd0, 0, 0, 0);
    run_vec(14, 32'h0000_0004, 32'h8000_0000, 0, 5'd9, 0, 0, 0);
    // R11: bitwise NOR
    run_vec(7, 32'h0F0F_0000, 32'h00F0_0000, 0, 0, 0, 0, 0);

    // Weighted random sweep over every code
    for (int i = 0; i < 4000; i++) begin
      run_vec(int'($urandom_range(0, 31)), pick(), pick(), pick_imm(),
              5'($urandom), $urandom & 32'hFFFF_FFFC, $urandom, 2'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule